// File: doc/BRIEF.md
# Sticky Power-Fail Status Flag

This block holds a single status bit that records a loss of supply. One of two sources can set the bit: a level detector inside the chip that watches the supply, or an active-low power-fail pin driven from outside. A mode-select pin, read together with the power-fail pin, picks the source. Both pins have slow edges, so both pins and the detector line pass through a two-stage synchronizer and a per-bit glitch filter before the block uses them.

Once the bit is set, it stays set after the supply comes back. The only way to clear it is a host write to the execute address of the serial-bus register file. That write reaches the block as a one-cycle strobe. The bit feeds the register file's status read path. One pin combination selects a test mode. In that mode neither source can set the bit, and a separate indicator output is high.

Top module: `pwrfail_flag`

## Requirements
- R1: While rst_ni is low and on release, flag_o is 1 and test_mode_o is 0. After reset the filtered inputs start at mode_sel=1, ext_pf_n=1, int_fail=0.
- R2: In a cycle with no set condition, a one-cycle exec_wr_i pulse makes flag_o 0 from the next rising edge.
- R3: Once flag_o is 1, it stays 1 until an exec_wr_i pulse, even after every fail source has returned to its healthy level.
- R4: With mode_sel_i=0 and ext_pf_ni=0 (internal-sense mode), a filtered int_fail_i of 1 sets flag_o. A value of 0 does not set it.
- R5: With mode_sel_i=0 and ext_pf_ni=1 (test mode), test_mode_o is 1 and flag_o is not set, whatever the value of int_fail_i. In the other three modes test_mode_o is 0.
- R6: With mode_sel_i=1 and ext_pf_ni=0, flag_o is set whatever the value of int_fail_i.
- R7: With mode_sel_i=1 and ext_pf_ni=1, flag_o is never set, and int_fail_i is ignored.
- R8: When a set condition and an exec_wr_i pulse fall in the same cycle, the set wins and flag_o stays 1.
- R9: A level change on mode_sel_i, ext_pf_ni or int_fail_i takes effect only after it has been held for FILT_LEN consecutive cycles at the synchronizer output. A pulse of FILT_LEN-1 cycles has no effect.
- R10: When a raw input is changed just before rising edge k into a set condition, flag_o goes to 1 at edge k+FILT_LEN+2 and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| int_fail_i | input | 1 | Internal supply detector, 1 = supply low (asynchronous) |
| ext_pf_ni | input | 1 | External power-fail pin, 0 = fail; also the mode decode bit (asynchronous) |
| mode_sel_i | input | 1 | Source select pin, 1 = external source (asynchronous) |
| exec_wr_i | input | 1 | One-cycle strobe for a host write to the execute address |
| flag_o | output | 1 | Sticky power-fail status bit |
| test_mode_o | output | 1 | High while the pins select test mode |

## Verification
The bench sweeps all eight combinations of the three fail and mode inputs. Each combination starts from a cleared flag, and each ends by returning to the healthy mode to confirm the bit stays set. This catches a wrong mode decode and a flag that clears when the supply recovers. Specific checks look for three more faults: a clear that beats a simultaneous set (the bit would drop during a live fault), a filter one cycle short (a FILT_LEN-1 glitch would set the bit), and an extra or missing pipeline stage (the bit would rise one edge off from k+FILT_LEN+2).

// File: rtl/pwrfail_pkg.sv
package pwrfail_pkg;
  // {mode_sel, ext_pf_n}
  typedef enum logic [1:0] {
    PF_MODE_INTSENSE = 2'b00,
    PF_MODE_TEST     = 2'b01,
    PF_MODE_EXTFAIL  = 2'b10,
    PF_MODE_EXTOK    = 2'b11
  } pf_mode_e;

  localparam int unsigned PF_NUM_IN = 3;
  localparam int unsigned PF_IDX_INT = 0;
  localparam int unsigned PF_IDX_PIN = 1;
  localparam int unsigned PF_IDX_SEL = 2;
  // reset levels: sel=1, pin=1, int=0 -> healthy external mode
  localparam logic [PF_NUM_IN-1:0] PF_IN_RST = 3'b110;

  function automatic pf_mode_e pf_decode(logic sel, logic pin_n);
    return pf_mode_e'({sel, pin_n});
  endfunction
endpackage

// File: rtl/pf_sync.sv
module pf_sync #(
  parameter int unsigned WIDTH = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [WIDTH-1:0] r_q;
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) r_q <= RST_VAL;
        else         r_q <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) r_q <= RST_VAL;
        else         r_q <= g_stage[s-1].r_q;
    end
  end
  assign q_o = g_stage[STAGES-1].r_q;
endmodule

// File: rtl/pf_filter.sv
module pf_filter #(
  parameter int unsigned LEN = 4,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  localparam int unsigned CW = (LEN < 2) ? 1 : $clog2(LEN);
  localparam logic [CW-1:0] LAST = CW'(LEN - 1);

  logic [CW-1:0] cnt_q;
  logic          lvl_q;

  // accept a new level after LEN consecutive differing samples
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      lvl_q <= RST_VAL;
    end else if (d_i == lvl_q) begin
      cnt_q <= '0;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
      lvl_q <= d_i;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
  assign q_o = lvl_q;
endmodule

// File: rtl/pf_flag_core.sv
module pf_flag_core
  import pwrfail_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic int_f_i,
  input  logic pin_f_i,
  input  logic sel_f_i,
  input  logic exec_wr_i,
  output logic flag_o,
  output logic test_mode_o
);
  pf_mode_e mode;
  logic     set_req;
  logic     flag_q;

  assign mode = pf_decode(sel_f_i, pin_f_i);

  always_comb begin
    unique case (mode)
      PF_MODE_INTSENSE: set_req = int_f_i;
      PF_MODE_EXTFAIL:  set_req = 1'b1;
      default:          set_req = 1'b0;
    endcase
  end

  // set has priority over the execute-address clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        flag_q <= 1'b1;
    else if (set_req)   flag_q <= 1'b1;
    else if (exec_wr_i) flag_q <= 1'b0;
  end

  assign flag_o      = flag_q;
  assign test_mode_o = (mode == PF_MODE_TEST);
endmodule

// File: rtl/pwrfail_flag.sv
module pwrfail_flag
  import pwrfail_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FILT_LEN = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic int_fail_i,
  input  logic ext_pf_ni,
  input  logic mode_sel_i,
  input  logic exec_wr_i,
  output logic flag_o,
  output logic test_mode_o
);
  logic [PF_NUM_IN-1:0] raw_in, sync_in, filt_in;

  assign raw_in[PF_IDX_INT] = int_fail_i;
  assign raw_in[PF_IDX_PIN] = ext_pf_ni;
  assign raw_in[PF_IDX_SEL] = mode_sel_i;

  pf_sync #(.WIDTH(PF_NUM_IN), .STAGES(SYNC_STAGES), .RST_VAL(PF_IN_RST)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw_in),
    .q_o   (sync_in)
  );

  for (genvar i = 0; i < PF_NUM_IN; i++) begin : g_filt
    pf_filter #(.LEN(FILT_LEN), .RST_VAL(PF_IN_RST[i])) u_filt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (sync_in[i]),
      .q_o   (filt_in[i])
    );
  end

  pf_flag_core u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .int_f_i    (filt_in[PF_IDX_INT]),
    .pin_f_i    (filt_in[PF_IDX_PIN]),
    .sel_f_i    (filt_in[PF_IDX_SEL]),
    .exec_wr_i  (exec_wr_i),
    .flag_o     (flag_o),
    .test_mode_o(test_mode_o)
  );
endmodule

// File: rtl/pwrfail_flag_chk.sv
module pwrfail_flag_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       exec_wr_i,
  input logic       flag_o,
  input logic       test_mode_o,
  input logic [2:0] filt_in
);
  logic f_int, f_pin, f_sel;
  assign f_int = filt_in[0];
  assign f_pin = filt_in[1];
  assign f_sel = filt_in[2];

  // R3: held unless cleared
  a_r3_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_o && !exec_wr_i |=> flag_o);

  // R8: external fail in the same cycle as a clear keeps the flag
  a_r8_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    f_sel && !f_pin && exec_wr_i |=> flag_o);

  // R4
  a_r4_int_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !f_sel && !f_pin && f_int |=> flag_o);

  // R5: no set in test mode
  a_r5_test_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    test_mode_o && !flag_o |=> !flag_o);

  // R7
  a_r7_ok_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    f_sel && f_pin && !flag_o |=> !flag_o);

  // R2
  a_r2_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    f_sel && f_pin && exec_wr_i |=> !flag_o);

  // R5: indicator only when sel low and pin high
  a_r5_ind: assert property (@(posedge clk_i) disable iff (!rst_ni)
    test_mode_o |-> (!f_sel && f_pin));
endmodule

bind pwrfail_flag pwrfail_flag_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .exec_wr_i  (exec_wr_i),
  .flag_o     (flag_o),
  .test_mode_o(test_mode_o),
  .filt_in    (filt_in)
);

// File: tb/pwrfail_flag_test.sv
`timescale 1ns/1ps
module pwrfail_flag_test;
  localparam int unsigned F = 3;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic int_fail_i = 1'b0, ext_pf_ni = 1'b1, mode_sel_i = 1'b1, exec_wr_i = 1'b0;
  logic flag_o, test_mode_o;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pwrfail_flag #(.SYNC_STAGES(2), .FILT_LEN(F)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .int_fail_i(int_fail_i), .ext_pf_ni(ext_pf_ni),
    .mode_sel_i(mode_sel_i), .exec_wr_i(exec_wr_i), .flag_o(flag_o),
    .test_mode_o(test_mode_o)
  );

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drive(logic sel, logic pin, logic intf);
    mode_sel_i = sel;
    ext_pf_ni  = pin;
    int_fail_i = intf;
  endtask

  task automatic settle();
    repeat (F + 4) tick();
  endtask

  task automatic pulse_exec();
    exec_wr_i = 1'b1;
    tick();
    exec_wr_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 flag in reset", flag_o, 1'b1);
    check("R1 test in reset", test_mode_o, 1'b0);
    rst_ni = 1'b1;
    tick();
    check("R1 flag after release", flag_o, 1'b1);
    check("R1 test after release", test_mode_o, 1'b0);

    // sweep all mode/source combinations
    for (int c = 0; c < 8; c++) begin
      logic s, p, n, exp_flag, exp_test;
      s = c[2]; p = c[1]; n = c[0];
      exp_flag = (!s && !p && n) || (s && !p);
      exp_test = !s && p;
      drive(1'b1, 1'b1, 1'b0);
      settle();
      pulse_exec();
      check("R2 clear", flag_o, 1'b0);
      drive(s, p, n);
      settle();
      if (!s && !p)     check("R4 internal sense", flag_o, exp_flag);
      else if (!s && p) check("R5 test mode flag", flag_o, exp_flag);
      else if (s && !p) check("R6 external fail", flag_o, exp_flag);
      else              check("R7 no fail", flag_o, exp_flag);
      check("R5 test indicator", test_mode_o, exp_test);
      drive(1'b1, 1'b1, 1'b0);
      settle();
      check("R3 sticky after recovery", flag_o, exp_flag);
    end

    // R8 set beats clear
    drive(1'b1, 1'b0, 1'b0);
    settle();
    pulse_exec();
    check("R8 set wins", flag_o, 1'b1);
    drive(1'b1, 1'b1, 1'b0);
    settle();
    pulse_exec();
    check("R2 clear after fault", flag_o, 1'b0);

    // R9 short glitch ignored, full-length accepted
    ext_pf_ni = 1'b0;
    repeat (F - 1) tick();
    ext_pf_ni = 1'b1;
    settle();
    check("R9 short glitch", flag_o, 1'b0);
    ext_pf_ni = 1'b0;
    repeat (F) tick();
    ext_pf_ni = 1'b1;
    settle();
    check("R9 full pulse", flag_o, 1'b1);
    pulse_exec();
    check("R2 clear again", flag_o, 1'b0);

    // R10 exact latency
    ext_pf_ni = 1'b0;
    repeat (F + 2) tick();
    check("R10 not yet", flag_o, 1'b0);
    tick();
    check("R10 on time", flag_o, 1'b1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule